// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps one descriptor for each packet that sits in the receive buffer. It always presents a 16-bit status word for the oldest packet. The MAC side reports packet starts, single received bytes and packet ends, and each end carries a 4-bit completion code. The host side reads bytes of the oldest packet with a read strobe. It drops that packet with a discard command, or clears everything with an RX reset. The packet data is held elsewhere, and this block tracks only the bookkeeping that describes it.

The status word is laid out as follows:
- Bit 15 flags a head packet that is not yet finished, or a queue with nothing in it.
- Bits 14..11 carry the completion code of a finished packet. Bit 14 set means the packet has an error.
- Bits 10..0 give the byte count.

The queue holds up to DEPTH descriptors. When all of them are in use, a status-overrun flag turns away new packets. A host read that goes past the bytes received so far for the head packet sets a sticky underrun error.

Top module: `rx_status_queue`

## Requirements
- R1: After reset, and whenever the queue holds no descriptor, the status word is 0x8000.
- R2: From the cycle after an accepted packet start until its end, `receiving` is high. While that packet is the head, the status word has bit 15 set, bits 14..11 zero, and bits 10..0 equal to the bytes received so far.
- R3: Once the head packet has ended, bit 15 is clear, bits 14..11 equal the 4-bit end code given with its end, and bits 10..0 hold its byte count. For example, code 1101 (CRC) on 3 bytes gives 0x6803, and code 0010 (dribble, not an error) on 2 bytes gives 0x1002.
- R4: The byte count saturates at MAX_BYTES (1514). If a byte arrives while the count is already at 1514, the packet ends with code 1001 (oversize) whatever end code is given. Exactly 1514 bytes keep the given code.
- R5: `rx_complete` is high for exactly one cycle, in the cycle after the end of an accepted packet. It stays low for the end of a refused packet.
- R6: Packets leave in arrival order. A discard removes the head, and the next descriptor appears in the following cycle. A discard on an empty queue has no effect.
- R7: While DEPTH (8) descriptors are held, `status_overrun` is high and a packet start is refused. The refused packet's bytes and end change nothing. The flag clears in the cycle after a discard.
- R8: A read strobe when the read position has reached the head's byte count, or when the queue is empty, sets `rx_underrun`. The flag then stays set through reads and discards.
- R9: RX reset empties the queue and clears `rx_underrun`, `receiving` and `status_overrun` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | MAC: a new packet begins |
| byte_rx | input | 1 | MAC: one byte of the current packet stored |
| pkt_end | input | 1 | MAC: current packet finished |
| end_code | input | 4 | MAC: completion code presented with pkt_end |
| rd_strobe | input | 1 | Host: read one byte of the head packet |
| discard_top | input | 1 | Host: drop the head packet |
| rx_reset | input | 1 | Host: clear the receive queue |
| status_word | output | 16 | Status of the head packet |
| rx_complete | output | 1 | One-cycle pulse per accepted packet end |
| status_overrun | output | 1 | All descriptors in use, so new packets are refused |
| rx_underrun | output | 1 | Sticky error: read past the received data |
| receiving | output | 1 | An accepted packet is being received |

## Verification
The hardest states to reach are at the edges of capacity. One is a full descriptor queue with a packet arriving against it. The other is a byte count that runs into its 1514 ceiling. The bench fills the queue with eight short packets of distinct lengths, then sends a complete ninth packet. It checks that the head word, the complete pulse and the receiving flag are left untouched, and that one discard frees the slot again. For saturation, it sends 1516 bytes and then exactly 1514 bytes, so that the forced oversize code and its absence at the limit are both seen.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CNT_W = 11;

    typedef struct packed {
        logic             done;
        logic [3:0]       code;
        logic [CNT_W-1:0] cnt;
    } rxq_desc_t;

    localparam logic [3:0]  CODE_OVERSIZE = 4'b1001;
    localparam logic [15:0] WORD_EMPTY    = 16'h8000;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         alloc,
    input  logic                         upd,
    input  rxq_desc_t                    upd_desc,
    input  logic                         pop,
    output rxq_desc_t                    head_desc,
    output logic                         head_valid,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH+1);

    typedef struct packed {
        rxq_desc_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [PW-1:0]         tail;
        logic [OW-1:0]         occ;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.occ = '0;
        end else begin
            if (upd)
                st_d.mem[st_q.tail] = upd_desc;
            if (pop && st_q.occ != '0) begin
                st_d.rp  = wrap_inc(st_q.rp);
                st_d.occ = st_d.occ - 1'b1;
            end
            if (alloc && st_q.occ != OW'(DEPTH)) begin
                st_d.mem[st_q.wp] = '0;
                st_d.tail         = st_q.wp;
                st_d.wp           = wrap_inc(st_q.wp);
                st_d.occ          = st_d.occ + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_desc  = st_q.mem[st_q.rp];
    assign head_valid = (st_q.occ != '0);
    assign occ        = st_q.occ;
    assign full       = (st_q.occ == OW'(DEPTH));
endmodule

// File: rtl/rxq_read_tracker.sv
module rxq_read_tracker
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rd,
    input  logic             pop,
    input  logic             head_valid,
    input  logic [CNT_W-1:0] head_cnt,
    output logic             underrun
);
    typedef struct packed {
        logic [CNT_W-1:0] off;
        logic             und;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    past_end;

    always_comb begin
        st_d     = st_q;
        past_end = !head_valid || (st_q.off >= head_cnt);
        if (clear) begin
            st_d = '0;
        end else begin
            if (pop)
                st_d.off = '0;
            else if (rd && !past_end)
                st_d.off = st_q.off + 1'b1;
            if (rd && past_end)
                st_d.und = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign underrun = st_q.und;
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int MAX_BYTES = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pkt_start,
    input  logic        byte_rx,
    input  logic        pkt_end,
    input  logic [3:0]  end_code,
    input  logic        rd_strobe,
    input  logic        discard_top,
    input  logic        rx_reset,
    output logic [15:0] status_word,
    output logic        rx_complete,
    output logic        status_overrun,
    output logic        rx_underrun,
    output logic        receiving
);
    localparam int OW = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

    typedef struct packed {
        logic             rcv;
        logic [CNT_W-1:0] cnt;
        logic             ovs;
        logic             rxc;
    } ctl_st_t;

    ctl_st_t   st_d, st_q;
    rxq_desc_t head_desc, upd_desc;
    logic      head_valid, full, upd, accept, pop, drop_cur;
    logic [OW-1:0] occ;

    assign accept   = pkt_start && !st_q.rcv && !full && !rx_reset;
    assign pop      = discard_top && head_valid && !rx_reset;
    assign drop_cur = pop && st_q.rcv && (occ == OW'(1));

    always_comb begin
        st_d     = st_q;
        st_d.rxc = 1'b0;
        upd      = 1'b0;
        upd_desc = '0;
        if (rx_reset) begin
            st_d = '0;
        end else if (accept) begin
            st_d.rcv = 1'b1;
            st_d.cnt = '0;
            st_d.ovs = 1'b0;
        end else if (drop_cur) begin
            st_d.rcv = 1'b0;
        end else if (st_q.rcv) begin
            if (byte_rx) begin
                if (st_q.cnt == CNT_MAX) st_d.ovs = 1'b1;
                else                     st_d.cnt = st_q.cnt + 1'b1;
            end
            upd_desc.cnt = st_d.cnt;
            if (pkt_end) begin
                st_d.rcv      = 1'b0;
                st_d.rxc      = 1'b1;
                upd_desc.done = 1'b1;
                upd_desc.code = st_d.ovs ? CODE_OVERSIZE : end_code;
            end
            upd = byte_rx || pkt_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_reset),
        .alloc      (accept),
        .upd        (upd),
        .upd_desc   (upd_desc),
        .pop        (pop),
        .head_desc  (head_desc),
        .head_valid (head_valid),
        .occ        (occ),
        .full       (full)
    );

    rxq_read_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rx_reset),
        .rd         (rd_strobe),
        .pop        (pop),
        .head_valid (head_valid),
        .head_cnt   (head_desc.cnt),
        .underrun   (rx_underrun)
    );

    always_comb begin
        if (!head_valid)
            status_word = WORD_EMPTY;
        else if (head_desc.done)
            status_word = {1'b0, head_desc.code, head_desc.cnt};
        else
            status_word = {1'b1, 4'b0000, head_desc.cnt};
    end

    assign rx_complete    = st_q.rxc;
    assign status_overrun = full;
    assign receiving      = st_q.rcv;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_start,
    input logic        rx_reset,
    input logic [15:0] status_word,
    input logic        rx_complete,
    input logic        status_overrun,
    input logic        rx_underrun,
    input logic        receiving
);
    assert_flag_fields_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] |-> status_word[14:11] == 4'b0000);

    assert_count_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[10:0] <= 11'd1514);

    assert_complete_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |=> !rx_complete);

    assert_complete_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !receiving);

    assert_no_accept_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_overrun && !receiving) |=> !receiving);

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_underrun && !rx_reset) |=> rx_underrun);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (status_word == 16'h8000 && !rx_underrun && !receiving && !status_overrun));

    assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!receiving && !pkt_start) |=> !receiving);
endmodule

bind rx_status_queue rxq_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_start      (pkt_start),
    .rx_reset       (rx_reset),
    .status_word    (status_word),
    .rx_complete    (rx_complete),
    .status_overrun (status_overrun),
    .rx_underrun    (rx_underrun),
    .receiving      (receiving)
);

// File: tb/sim_rx_status_queue.sv
`timescale 1ns/1ps
module sim_rx_status_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0, byte_rx = 1'b0, pkt_end = 1'b0;
    logic [3:0]  end_code = 4'h0;
    logic        rd_strobe = 1'b0, discard_top = 1'b0, rx_reset = 1'b0;
    logic [15:0] status_word;
    logic        rx_complete, status_overrun, rx_underrun, receiving;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rx_status_queue u0 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_rx(byte_rx),
        .pkt_end(pkt_end), .end_code(end_code), .rd_strobe(rd_strobe),
        .discard_top(discard_top), .rx_reset(rx_reset),
        .status_word(status_word), .rx_complete(rx_complete),
        .status_overrun(status_overrun), .rx_underrun(rx_underrun),
        .receiving(receiving)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with the given inputs held over the edge; results sampled 1 ns after it
    task automatic tick(input logic s, input logic b, input logic e, input logic [3:0] c,
                        input logic r, input logic d, input logic x);
        @(negedge clk);
        pkt_start = s; byte_rx = b; pkt_end = e; end_code = c;
        rd_strobe = r; discard_top = d; rx_reset = x;
        @(posedge clk);
        #1;
        pkt_start = 0; byte_rx = 0; pkt_end = 0; end_code = 0;
        rd_strobe = 0; discard_top = 0; rx_reset = 0;
    endtask

    task automatic send_pkt(input int n, input logic [3:0] c);
        tick(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n; i++) tick(0, 1, 0, 0, 0, 0, 0);
        tick(0, 0, 1, c, 0, 0, 0);
    endtask

    task automatic do_reset_q();
        tick(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_reset_state();
        check("R1 status after reset", status_word, 16'h8000);
        check("R1 overrun after reset", {15'd0, status_overrun}, 16'd0);
        check("R1 underrun after reset", {15'd0, rx_underrun}, 16'd0);
        check("R1 receiving after reset", {15'd0, receiving}, 16'd0);
    endtask

    task automatic t_progress();
        tick(1, 0, 0, 0, 0, 0, 0);
        check("R2 receiving after start", {15'd0, receiving}, 16'd1);
        check("R2 incomplete zero count", status_word, 16'h8000);
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 0, 0, 0, 0);
        check("R2 running count", status_word, 16'h8005);
        tick(0, 0, 1, 4'b0000, 0, 0, 0);
        check("R5 complete pulse", {15'd0, rx_complete}, 16'd1);
        check("R3 good packet word", status_word, 16'h0005);
        check("R2 receiving low after end", {15'd0, receiving}, 16'd0);
        tick(0, 0, 0, 0, 0, 0, 0);
        check("R5 pulse one cycle", {15'd0, rx_complete}, 16'd0);
        do_reset_q();
    endtask

    task automatic t_codes_order();
        send_pkt(3, 4'b1101);
        send_pkt(2, 4'b0010);
        send_pkt(7, 4'b1011);
        check("R3 crc code word", status_word, 16'h6803);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R6 second after discard", status_word, 16'h1002);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R6 third after discard", status_word, 16'h5807);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R6 empty after last discard", status_word, 16'h8000);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R6 discard on empty", status_word, 16'h8000);
        check("R6 discard empty no underrun", {15'd0, rx_underrun}, 16'd0);
        send_pkt(4, 4'b0000);
        check("R6 queue works after empty discard", status_word, 16'h0004);
        do_reset_q();
    endtask

    task automatic t_saturate();
        send_pkt(1516, 4'b0000);
        check("R4 oversize forced", status_word, 16'h4DEA);
        tick(0, 0, 0, 0, 0, 1, 0);
        send_pkt(1514, 4'b0000);
        check("R4 exact limit keeps code", status_word, 16'h05EA);
        do_reset_q();
    endtask

    task automatic t_full();
        for (int k = 1; k <= 8; k++) send_pkt(k, 4'b0000);
        check("R7 overrun when eight held", {15'd0, status_overrun}, 16'd1);
        tick(1, 0, 0, 0, 0, 0, 0);
        check("R7 start refused", {15'd0, receiving}, 16'd0);
        tick(0, 1, 0, 0, 0, 0, 0);
        tick(0, 0, 1, 4'b1101, 0, 0, 0);
        check("R5 no pulse for refused", {15'd0, rx_complete}, 16'd0);
        check("R7 head untouched", status_word, 16'h0001);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R7 overrun clears", {15'd0, status_overrun}, 16'd0);
        check("R6 next head", status_word, 16'h0002);
        tick(1, 0, 0, 0, 0, 0, 0);
        check("R7 accepted after free", {15'd0, receiving}, 16'd1);
        tick(0, 0, 1, 4'b0000, 0, 0, 0);
        do_reset_q();
        check("R9 reset clears full", {15'd0, status_overrun}, 16'd0);
        check("R9 reset empties", status_word, 16'h8000);
    endtask

    task automatic t_underrun();
        send_pkt(3, 4'b0000);
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 1, 0, 0);
        check("R8 no underrun within data", {15'd0, rx_underrun}, 16'd0);
        tick(0, 0, 0, 0, 1, 0, 0);
        check("R8 underrun past end", {15'd0, rx_underrun}, 16'd1);
        tick(0, 0, 0, 0, 0, 1, 0);
        check("R8 underrun sticky on discard", {15'd0, rx_underrun}, 16'd1);
        do_reset_q();
        check("R9 reset clears underrun", {15'd0, rx_underrun}, 16'd0);
        tick(0, 0, 0, 0, 1, 0, 0);
        check("R8 read on empty", {15'd0, rx_underrun}, 16'd1);
        tick(1, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 1);
        check("R9 reset stops receiving", {15'd0, receiving}, 16'd0);
        check("R9 reset clears underrun again", {15'd0, rx_underrun}, 16'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_progress();
        t_codes_order();
        t_saturate();
        t_full();
        t_underrun();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule